// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external asynchronous static RAM of 512K words by 8 bits. The host offers one request at a time through a request/ready handshake. A request carries a 19-bit address, a write flag and 8 bits of write data. The controller turns each request into a strobe sequence on the memory pins. That sequence meets the memory's minimum timing limits, which are given in nanoseconds and converted into whole clock cycles.

The memory is selected only when its active-low enable is low and its active-high enable is high. The controller always moves the two enables together. A read opens the output path and holds it until the access time has passed. It then latches the returned byte and signals the host with a one-cycle valid pulse. A write drives the data bus with the output path closed and pulses the write strobe. It then holds address and data for a short recovery phase. After every read the controller waits out the memory's output turn-off time before it can enable its own bus drivers again.

Each limit becomes a cycle count through ceiling division by the clock period parameter. Any nonzero limit takes at least one cycle. With the default 10 ns clock the read phase lasts 9 cycles, the turnaround 3, write setup 1, the write pulse 6 and the recovery 1.

Top module: `asram_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, the memory is deselected (mem_ce_n_o=1, mem_ce_o=0), mem_we_n_o=1, mem_oe_n_o=1, mem_dq_oe_o=0 and rvalid_o=0.
- R2: ready_o is high only when no access is in progress, and all memory strobes are then inactive. A request is taken at a rising clock edge where req_i and ready_o are both high, and ready_o is low in the following cycle.
- R3: The two chip enables always carry opposite levels (mem_ce_n_o equals the inverse of mem_ce_o). They are active for every cycle of a read or write access and inactive otherwise.
- R4: During a read, mem_oe_n_o=0 and mem_we_n_o=1. mem_dq_i is latched at the end of the read's RD_CYC-th cycle, where RD_CYC = ceil(max(access, cycle time)/clock) = 9 by default. rvalid_o is high for exactly one cycle, and rdata_o holds the latched byte in that cycle. The pulse is seen RD_CYC cycles after acceptance.
- R5: mem_oe_n_o stays high for the whole write. mem_we_n_o is low only while the chip is selected, for WP_CYC = ceil(max(pulse, data setup)/clock) = 6 cycles by default.
- R6: The address is driven for at least the address-to-end-of-write limit (70 ns by default) before mem_we_n_o rises. The setup phase lasts max(1, ceil((70 - WP_CYC*clock)/clock)) = 1 cycle.
- R7: Address and write data are driven and unchanged throughout the write pulse and for REC_CYC = max(1, ceil(recovery/clock)) = 1 cycle after mem_we_n_o rises.
- R8: mem_dq_oe_o is never high while mem_oe_n_o is low. After a read, the controller keeps its drivers off and ready_o low for HZ_CYC = ceil(turn-off/clock) = 3 cycles. The busy time of a read is RD_CYC+HZ_CYC = 12 cycles.
- R9: A read returns the byte most recently written to the same address.
- R10: A write keeps ready_o low for SU_CYC+WP_CYC+REC_CYC = 8 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| ready_o | output | 1 | Controller idle, request can be taken |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Host address |
| wdata_i | input | DATA_W | Host write data |
| rdata_o | output | DATA_W | Latched read data |
| rvalid_o | output | 1 | One-cycle read-data strobe |
| mem_addr_o | output | ADDR_W | Memory address bus |
| mem_ce_n_o | output | 1 | Memory enable, active low |
| mem_ce_o | output | 1 | Memory enable, active high |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_we_n_o | output | 1 | Memory write strobe, active low |
| mem_dq_o | output | DATA_W | Data bus, driven value |
| mem_dq_i | input | DATA_W | Data bus, received value |
| mem_dq_oe_o | output | 1 | Data bus driver enable |

## Verification
Several rules are checked on every clock: the enables move as a pair, output enable and the write strobe are never low together, the strobe never falls without selection, address and data stay still across the pulse and recovery, the pulse lasts its minimum length, and the drivers wait out the turn-off window. Other behaviour can only be shown by the bench's scenarios against its behavioural memory model. This covers read data arriving after the access time, the exact busy cycle counts, and read-after-write integrity across a sweep of walking-one addresses with back-to-back read and write pairs.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_CAPTURE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER,
    ST_TURNAROUND
  } state_t;

  typedef struct packed {
    logic sel;
    logic rd_en;
    logic wr_en;
    logic drive;
  } pins_t;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // ns limit -> clocks, nonzero limits take at least one cycle
  function automatic int ns2cyc(int ns, int clk_ns);
    if (ns <= 0) return 0;
    return max2(1, (ns + clk_ns - 1) / clk_ns);
  endfunction

  function automatic pins_t pin_decode(state_t s);
    pins_t p;
    p = '0;
    case (s)
      ST_RD_ACCESS, ST_RD_CAPTURE: begin
        p.sel   = 1'b1;
        p.rd_en = 1'b1;
      end
      ST_WR_SETUP, ST_WR_RECOVER: begin
        p.sel   = 1'b1;
        p.drive = 1'b1;
      end
      ST_WR_PULSE: begin
        p.sel   = 1'b1;
        p.wr_en = 1'b1;
        p.drive = 1'b1;
      end
      default: p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/asram_phase_cnt.sv
module asram_phase_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/asram_rd_cap.sv
module asram_rd_cap #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o,
  output logic              valid_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= cap_i;
      if (cap_i) q_o <= d_i;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int CLK_NS  = 10,
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 8,
  parameter int T_AA_NS = 85,
  parameter int T_RC_NS = 85,
  parameter int T_WP_NS = 60,
  parameter int T_AW_NS = 70,
  parameter int T_DW_NS = 40,
  parameter int T_WR_NS = 5,
  parameter int T_HZ_NS = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  output logic              ready_o,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_ce_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe_o
);

  localparam int RD_CYC  = max2(1, ns2cyc(max2(T_AA_NS, T_RC_NS), CLK_NS));
  localparam int WP_CYC  = max2(1, ns2cyc(max2(T_WP_NS, T_DW_NS), CLK_NS));
  localparam int SU_CYC  = max2(1, ns2cyc(T_AW_NS - WP_CYC * CLK_NS, CLK_NS));
  localparam int REC_CYC = max2(1, ns2cyc(T_WR_NS, CLK_NS));
  localparam int HZ_CYC  = ns2cyc(T_HZ_NS, CLK_NS);
  localparam int MAX_CYC = max2(max2(RD_CYC, WP_CYC), max2(max2(SU_CYC, REC_CYC), HZ_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  state_t            state_q, state_d;
  pins_t             pins_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              ld;
  logic [CNT_W-1:0]  ld_val;
  logic              ph_done;
  logic              cap;
  logic              accept;

  assign accept = req_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ld_val  = '0;
    cap     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          ld = 1'b1;
          if (we_i) begin
            state_d = ST_WR_SETUP;
            ld_val  = CNT_W'(SU_CYC - 1);
          end else if (RD_CYC > 1) begin
            state_d = ST_RD_ACCESS;
            ld_val  = CNT_W'(RD_CYC - 2);
          end else begin
            state_d = ST_RD_CAPTURE;
          end
        end
      end
      ST_RD_ACCESS: if (ph_done) state_d = ST_RD_CAPTURE;
      ST_RD_CAPTURE: begin
        cap = 1'b1;
        if (HZ_CYC > 0) begin
          state_d = ST_TURNAROUND;
          ld      = 1'b1;
          ld_val  = CNT_W'(HZ_CYC - 1);
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_WR_SETUP: if (ph_done) begin
        state_d = ST_WR_PULSE;
        ld      = 1'b1;
        ld_val  = CNT_W'(WP_CYC - 1);
      end
      ST_WR_PULSE: if (ph_done) begin
        state_d = ST_WR_RECOVER;
        ld      = 1'b1;
        ld_val  = CNT_W'(REC_CYC - 1);
      end
      ST_WR_RECOVER: if (ph_done) state_d = ST_IDLE;
      ST_TURNAROUND: if (ph_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pins_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      pins_q  <= pin_decode(state_d);  // glitch-free pins, aligned with state_q
      if (accept) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
    end
  end

  asram_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ld),
    .val_i  (ld_val),
    .done_o (ph_done)
  );

  asram_rd_cap #(.DATA_W(DATA_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .d_i     (mem_dq_i),
    .q_o     (rdata_o),
    .valid_o (rvalid_o)
  );

  assign ready_o     = (state_q == ST_IDLE);
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign mem_ce_n_o  = !pins_q.sel;
  assign mem_ce_o    = pins_q.sel;
  assign mem_oe_n_o  = !pins_q.rd_en;
  assign mem_we_n_o  = !pins_q.wr_en;
  assign mem_dq_oe_o = pins_q.drive;

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk
  import asram_pkg::*;
#(
  parameter int CLK_NS  = 10,
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 8,
  parameter int T_WP_NS = 60,
  parameter int T_DW_NS = 40,
  parameter int T_HZ_NS = 30
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ready_o,
  input logic              rvalid_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ce_n_o,
  input logic              mem_ce_o,
  input logic              mem_oe_n_o,
  input logic              mem_we_n_o,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe_o
);

  localparam int WP_CYC = max2(1, ns2cyc(max2(T_WP_NS, T_DW_NS), CLK_NS));
  localparam int HZ_CYC = ns2cyc(T_HZ_NS, CLK_NS);

  logic [7:0] wp_cnt;
  logic [7:0] hz_cnt;
  logic       mem_drv;

  assign mem_drv = mem_ce_o && !mem_ce_n_o && !mem_oe_n_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_cnt <= '0;
      hz_cnt <= '1;
    end else begin
      if (!mem_we_n_o) wp_cnt <= (wp_cnt == 8'hff) ? wp_cnt : wp_cnt + 1'b1;
      else             wp_cnt <= '0;
      if (mem_drv)     hz_cnt <= '0;
      else             hz_cnt <= (hz_cnt == 8'hff) ? hz_cnt : hz_cnt + 1'b1;
    end
  end

  AST_CE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ce_n_o == !mem_ce_o); // R3
  AST_NO_OE_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> mem_oe_n_o); // R5
  AST_WE_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (mem_ce_o && !mem_ce_n_o)); // R5
  AST_WP_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (int'(wp_cnt) >= WP_CYC)); // R5
  AST_HOLD_IN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> ($stable(mem_addr_o) && $stable(mem_dq_o) && mem_dq_oe_o)); // R7
  AST_HOLD_AFTER_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!mem_we_n_o) |-> ($stable(mem_addr_o) && $stable(mem_dq_o) && mem_dq_oe_o)); // R7
  AST_DRV_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_n_o); // R8
  AST_HZ_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> (int'(hz_cnt) >= HZ_CYC)); // R8
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (mem_ce_n_o && !mem_ce_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o)); // R2
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o); // R2
  AST_RVALID_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o); // R4
  AST_RVALID_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(!mem_oe_n_o)); // R4

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .CLK_NS  (CLK_NS),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .T_WP_NS (T_WP_NS),
  .T_DW_NS (T_DW_NS),
  .T_HZ_NS (T_HZ_NS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .ready_o     (ready_o),
  .rvalid_o    (rvalid_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ce_n_o  (mem_ce_n_o),
  .mem_ce_o    (mem_ce_o),
  .mem_oe_n_o  (mem_oe_n_o),
  .mem_we_n_o  (mem_we_n_o),
  .mem_dq_o    (mem_dq_o),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
module sim_asram_ctrl;

  localparam int CLK = 10;
  localparam int AW  = 19;
  localparam int DW  = 8;
  localparam int TAA = 85;
  localparam int TWP = 60;
  localparam int TAW = 70;
  localparam int THZ = 30;
  // expected cycle counts, worked out from the limits
  localparam int E_RD  = (TAA + CLK - 1) / CLK;           // 9
  localparam int E_WP  = (TWP + CLK - 1) / CLK;           // 6
  localparam int E_SU  = 1;                               // (70-60)/10
  localparam int E_REC = 1;
  localparam int E_HZ  = (THZ + CLK - 1) / CLK;           // 3
  localparam int E_WR_BUSY = E_SU + E_WP + E_REC;         // 8
  localparam int E_RD_BUSY = E_RD + E_HZ;                 // 12

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          ready_o, rvalid_o;
  logic [DW-1:0] rdata_o;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_o;
  logic [DW-1:0] mem_dq_i = '0;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  asram_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .ready_o(ready_o), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .mem_addr_o(mem_addr), .mem_ce_n_o(mem_ce_n), .mem_ce_o(mem_ce),
    .mem_oe_n_o(mem_oe_n), .mem_we_n_o(mem_we_n), .mem_dq_o(mem_dq_o),
    .mem_dq_i(mem_dq_i), .mem_dq_oe_o(mem_dq_oe)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // behavioural memory, evaluated at the falling edge on the pins of the current cycle
  logic [DW-1:0] sram [int];
  logic [DW-1:0] ref_mem [int];
  int age, wp, aw_end, rd_age, hz;
  bit wr_l, rd_l, sel_l;
  logic [AW-1:0] a_l;
  logic [DW-1:0] d_l;

  function automatic logic [DW-1:0] sram_rd(input logic [AW-1:0] a);
    return sram.exists(int'(a)) ? sram[int'(a)] : '0;
  endfunction

  always @(negedge clk) begin
    bit sel, rd, wr;
    if (!rst_ni) begin
      age = 0; wp = 0; aw_end = 0; rd_age = 0; hz = 1000;
      wr_l = 0; rd_l = 0; sel_l = 0; a_l = '0; d_l = '0;
    end else begin
      sel = !mem_ce_n && mem_ce;
      rd  = sel && !mem_oe_n && mem_we_n;
      wr  = sel && !mem_we_n;
      if (!mem_we_n && !sel) chk(0, "R5", "write strobe while deselected", 0, 1);
      if (sel) age = (sel_l && mem_addr == a_l) ? age + 1 : 1;
      else     age = 0;
      if (wr) begin
        if (!mem_oe_n) chk(0, "R5", "output enable low during write", 0, 1);
        if (!mem_dq_oe) chk(0, "R7", "data not driven during pulse", 0, 1);
        if (wr_l && (mem_addr != a_l || mem_dq_o != d_l))
          chk(0, "R7", "address/data moved in pulse", int'(mem_addr), int'(a_l));
        wp++;
        aw_end = age;
      end
      if (!wr && wr_l) begin
        chk(wp * CLK >= TWP, "R5", "write pulse ns", wp * CLK, TWP);
        chk(aw_end * CLK >= TAW, "R6", "address valid to end of write ns", aw_end * CLK, TAW);
        chk(mem_addr == a_l && mem_dq_o == d_l && mem_dq_oe, "R7", "recovery hold",
            int'(mem_addr), int'(a_l));
        sram[int'(a_l)] = d_l;
        wp = 0;
      end
      if (rd) rd_age = (rd_l && mem_addr == a_l) ? rd_age + 1 : 1;
      else    rd_age = 0;
      if (rd) hz = 0;
      else if (hz < 1000) hz = hz + CLK;
      if (mem_dq_oe && (rd || hz < THZ + CLK))
        chk(0, "R8", "driver on inside turn-off window ns", hz - CLK, THZ);
      mem_dq_i = (rd_age * CLK >= TAA) ? sram_rd(mem_addr) : ~sram_rd(mem_addr);
      a_l = mem_addr; d_l = mem_dq_o; wr_l = wr; rd_l = rd; sel_l = sel;
    end
  end

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int n;
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    ref_mem[int'(a)] = d;
    chk(!ready_o && !mem_ce_n == mem_ce && mem_ce, "R3", "enables active in write", int'(mem_ce), 1);
    n = 0;
    while (!ready_o) begin
      n++;
      @(negedge clk);
    end
    chk(n == E_WR_BUSY, "R10", "write busy cycles", n, E_WR_BUSY);
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    int n, rv_cnt, rv_at;
    logic [DW-1:0] got, exp;
    req = 1'b1; we = 1'b0; addr = a;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    chk(!ready_o, "R2", "ready after accept", int'(ready_o), 0);
    chk(!mem_ce_n && mem_ce, "R3", "enables active in read", int'(mem_ce), 1);
    chk(!mem_oe_n && mem_we_n, "R4", "read strobes oe_n/we_n", int'({mem_oe_n, mem_we_n}), 1);
    n = 0; rv_cnt = 0; rv_at = -1; got = '0;
    while (!ready_o) begin
      if (rvalid_o) begin
        rv_cnt++;
        rv_at = n;
        got = rdata_o;
      end
      if (n >= E_RD && mem_dq_oe) chk(0, "R8", "driver on in turnaround", 1, 0);
      n++;
      @(negedge clk);
    end
    exp = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : '0;
    chk(rv_cnt == 1, "R4", "rvalid pulse width", rv_cnt, 1);
    chk(rv_at == E_RD, "R4", "rvalid latency", rv_at, E_RD);
    chk(got == exp, "R9", "read data", int'(got), int'(exp));
    chk(n == E_RD_BUSY, "R8", "read busy cycles incl. turnaround", n, E_RD_BUSY);
    chk(mem_ce_n && !mem_ce, "R3", "enables inactive when idle", int'(mem_ce), 0);
  endtask

  function automatic logic [AW-1:0] sweep_addr(input int i);
    if (i == 0)  return '0;
    if (i == AW + 1) return '1;
    return AW'(1) << (i - 1);
  endfunction

  function automatic logic [DW-1:0] pat(input int i, input int pass);
    return DW'(i * 37 + pass * 101 + 5);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R2", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(mem_ce_n && !mem_ce, "R1", "enables in reset", int'(mem_ce), 0);
    chk(mem_we_n && mem_oe_n, "R1", "we_n/oe_n in reset", int'({mem_we_n, mem_oe_n}), 3);
    chk(!mem_dq_oe && !rvalid_o, "R1", "driver/rvalid in reset", int'({mem_dq_oe, rvalid_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(ready_o, "R2", "ready after reset", int'(ready_o), 1);
    chk(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe, "R1",
        "pins after reset", int'({mem_ce_n, mem_we_n, mem_oe_n}), 7);

    // pass 1: walking-one address sweep, all writes then all reads
    for (int i = 0; i <= AW + 1; i++) do_write(sweep_addr(i), pat(i, 0));
    for (int i = 0; i <= AW + 1; i++) do_read(sweep_addr(i));
    // pass 2: read-after-write pairs, read followed at once by the next write
    for (int i = AW + 1; i >= 0; i--) begin
      do_write(sweep_addr(i), pat(i, 1));
      do_read(sweep_addr(i));
    end
    // back-to-back reads and overwrite of one location
    do_write(sweep_addr(3), 8'hA5);
    do_write(sweep_addr(3), 8'h3C);
    do_read(sweep_addr(3));
    do_read(sweep_addr(4));
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule